// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Stall Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it takes the register fields and control bits of the instruction in decode. It carries the destination and control information of older instructions forward in its own execute, memory and write-back tracking registers. It then compares source register numbers against destination register numbers further down the pipe.

Two operand select codes come out of the comparison. They steer the datapath's ALU input multiplexers to the register file value, the result at the end of the memory stage register, or the result at the end of the write-back stage register. A load whose result is wanted by the very next instruction cannot be forwarded in time. For that case the block raises a stall: the program counter and the fetch/decode register hold, and a bubble enters execute. A taken-branch flush request clears the fetch/decode register and wins over any stall raised in the same cycle. The register file is assumed to write in the first half of a cycle and read in the second, so a result being written back needs no path into decode.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When a used, nonzero source of the instruction in execute equals the destination of the instruction one stage ahead (memory stage) and that instruction writes a register, the operand select is 2'b10.
- R2: When a used, nonzero source of the instruction in execute matches only the destination of a register-writing instruction two stages ahead (write-back stage), the operand select is 2'b01. With no match the select is 2'b00.
- R3: When both the memory-stage and the write-back-stage destinations match the same source, the nearer one wins and the select is 2'b10. The select is never 2'b11.
- R4: Register number 0 is never forwarded and never causes a stall, whether it appears as a source or as a load destination.
- R5: A source whose use flag is low is never forwarded and never causes a stall.
- R6: When a used, nonzero decode source equals the destination of a register-writing load in execute, pc_hold_o, ifid_hold_o and ex_bubble_o go high in that same cycle. With the same instruction held in decode, they are low in the following cycle, so the stall lasts exactly one cycle.
- R7: In the cycle after a stall, the execute-stage register-write and memory-write outputs are low and both operand selects are 2'b00.
- R8: An ALU (non-load) producer followed at once by a consumer never causes a stall; the dependency is covered by forwarding alone.
- R9: flush_i drives ifid_clr_o high in the same cycle and forces pc_hold_o, ifid_hold_o and ex_bubble_o low, even when a load-use match is present.
- R10: A load that has already reached the memory stage causes no stall; its result is forwarded instead.
- R11: Synchronous reset clears all tracking registers: after a reset edge the execute-stage write outputs are low, the selects are 2'b00 and no stall is raised.
- R12: Without a stall, the decode-stage register-write and memory-write bits appear on ex_wr_o and ex_mw_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| id_rs1_i | input | REG_AW | First source register of the decode instruction |
| id_rs2_i | input | REG_AW | Second source register of the decode instruction |
| id_use1_i | input | 1 | First source is read by the decode instruction |
| id_use2_i | input | 1 | Second source is read by the decode instruction |
| id_rd_i | input | REG_AW | Destination register of the decode instruction |
| id_wr_i | input | 1 | Decode instruction writes a register |
| id_load_i | input | 1 | Decode instruction is a load |
| id_mw_i | input | 1 | Decode instruction writes memory |
| flush_i | input | 1 | Taken-branch flush request |
| fwd_a_o | output | 2 | First ALU operand select: 00 register file, 01 write-back stage, 10 memory stage |
| fwd_b_o | output | 2 | Second ALU operand select, same encoding |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| ex_bubble_o | output | 1 | Insert a bubble into execute at the next edge |
| ifid_clr_o | output | 1 | Clear the fetch/decode register |
| ex_wr_o | output | 1 | Register-write bit of the instruction now in execute |
| ex_mw_o | output | 1 | Memory-write bit of the instruction now in execute |

## Verification
The stall and flush outputs depend combinationally on the decode inputs and on the execute tracking register, so they are due in the same cycle as the stimulus. The operand selects and the execute-stage write bits describe the instruction issued one row earlier, so they are due one clock after it. The bench drives each row on the falling edge and samples one nanosecond later, before the next rising edge. Each row's expected selects are therefore worked out from the rows one, two and three positions back in the table, with a stalled row repeated to match what the pipeline really holds.

// File: rtl/phc_pkg.sv
package phc_pkg;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_EXM = 2'b10
   } fwd_sel_e;

   localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/phc_stage_regs.sv
module phc_stage_regs #(
   parameter int unsigned REG_AW = 5
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              bubble_i,
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic              id_use1_i,
   input  logic              id_use2_i,
   input  logic [REG_AW-1:0] id_rd_i,
   input  logic              id_wr_i,
   input  logic              id_load_i,
   input  logic              id_mw_i,
   output logic [REG_AW-1:0] ex_rs1_o,
   output logic [REG_AW-1:0] ex_rs2_o,
   output logic              ex_use1_o,
   output logic              ex_use2_o,
   output logic [REG_AW-1:0] ex_rd_o,
   output logic              ex_wr_o,
   output logic              ex_load_o,
   output logic              ex_mw_o,
   output logic [REG_AW-1:0] mem_rd_o,
   output logic              mem_wr_o,
   output logic [REG_AW-1:0] wb_rd_o,
   output logic              wb_wr_o
);

   typedef struct packed {
      logic [REG_AW-1:0] rs1;
      logic [REG_AW-1:0] rs2;
      logic              use1;
      logic              use2;
      logic [REG_AW-1:0] rd;
      logic              wr;
      logic              load;
      logic              mw;
   } ex_slot_t;

   typedef struct packed {
      logic [REG_AW-1:0] rd;
      logic              wr;
   } dst_slot_t;

   ex_slot_t  ex_q, ex_d;
   dst_slot_t mem_q, wb_q;

   always_comb begin
      ex_d.rs1  = id_rs1_i;
      ex_d.rs2  = id_rs2_i;
      ex_d.rd   = id_rd_i;
      ex_d.use1 = id_use1_i & ~bubble_i;
      ex_d.use2 = id_use2_i & ~bubble_i;
      ex_d.wr   = id_wr_i   & ~bubble_i;
      ex_d.load = id_load_i & ~bubble_i;
      ex_d.mw   = id_mw_i   & ~bubble_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ex_q  <= '0;
         mem_q <= '0;
         wb_q  <= '0;
      end else begin
         ex_q     <= ex_d;
         mem_q.rd <= ex_q.rd;
         mem_q.wr <= ex_q.wr;
         wb_q     <= mem_q;
      end
   end

   assign ex_rs1_o  = ex_q.rs1;
   assign ex_rs2_o  = ex_q.rs2;
   assign ex_use1_o = ex_q.use1;
   assign ex_use2_o = ex_q.use2;
   assign ex_rd_o   = ex_q.rd;
   assign ex_wr_o   = ex_q.wr;
   assign ex_load_o = ex_q.load;
   assign ex_mw_o   = ex_q.mw;
   assign mem_rd_o  = mem_q.rd;
   assign mem_wr_o  = mem_q.wr;
   assign wb_rd_o   = wb_q.rd;
   assign wb_wr_o   = wb_q.wr;

endmodule

// File: rtl/phc_fwd_pick.sv
module phc_fwd_pick
   import phc_pkg::*;
#(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic              use_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_wr_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic              wb_wr_i,
   output logic [1:0]        sel_o
);

   logic live_src;
   logic hit_mem;
   logic hit_wb;
   fwd_sel_e sel;

   assign live_src = use_i && (src_i != '0);
   assign hit_mem  = live_src && mem_wr_i && (mem_rd_i == src_i);
   assign hit_wb   = live_src && wb_wr_i  && (wb_rd_i  == src_i);

   always_comb begin
      if (hit_mem)     sel = FWD_EXM;
      else if (hit_wb) sel = FWD_WB;
      else             sel = FWD_RF;
   end

   assign sel_o = sel;

endmodule

// File: rtl/phc_load_use.sv
module phc_load_use #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic              id_use1_i,
   input  logic              id_use2_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_wr_i,
   input  logic              ex_load_i,
   input  logic              flush_i,
   output logic              stall_o
);

   logic load_live;
   logic hit1;
   logic hit2;

   assign load_live = ex_load_i && ex_wr_i && (ex_rd_i != '0);
   assign hit1      = id_use1_i && (id_rs1_i == ex_rd_i);
   assign hit2      = id_use2_i && (id_rs2_i == ex_rd_i);
   assign stall_o   = load_live && (hit1 || hit2) && !flush_i;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import phc_pkg::*;
#(
   parameter int unsigned REG_AW = 5
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic              id_use1_i,
   input  logic              id_use2_i,
   input  logic [REG_AW-1:0] id_rd_i,
   input  logic              id_wr_i,
   input  logic              id_load_i,
   input  logic              id_mw_i,
   input  logic              flush_i,
   output logic [1:0]        fwd_a_o,
   output logic [1:0]        fwd_b_o,
   output logic              pc_hold_o,
   output logic              ifid_hold_o,
   output logic              ex_bubble_o,
   output logic              ifid_clr_o,
   output logic              ex_wr_o,
   output logic              ex_mw_o
);

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("pipe_hazard_ctrl: REG_AW must lie in 1..8");
      end
   endgenerate

   logic              stall;
   logic [REG_AW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic              ex_use1, ex_use2, ex_wr, ex_load, ex_mw;
   logic              mem_wr, wb_wr;

   logic [REG_AW-1:0] opnd_src [NUM_OPND];
   logic              opnd_use [NUM_OPND];
   logic [1:0]        opnd_sel [NUM_OPND];

   phc_stage_regs #(.REG_AW(REG_AW)) u_stages (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .bubble_i  (stall),
      .id_rs1_i  (id_rs1_i),
      .id_rs2_i  (id_rs2_i),
      .id_use1_i (id_use1_i),
      .id_use2_i (id_use2_i),
      .id_rd_i   (id_rd_i),
      .id_wr_i   (id_wr_i),
      .id_load_i (id_load_i),
      .id_mw_i   (id_mw_i),
      .ex_rs1_o  (ex_rs1),
      .ex_rs2_o  (ex_rs2),
      .ex_use1_o (ex_use1),
      .ex_use2_o (ex_use2),
      .ex_rd_o   (ex_rd),
      .ex_wr_o   (ex_wr),
      .ex_load_o (ex_load),
      .ex_mw_o   (ex_mw),
      .mem_rd_o  (mem_rd),
      .mem_wr_o  (mem_wr),
      .wb_rd_o   (wb_rd),
      .wb_wr_o   (wb_wr)
   );

   phc_load_use #(.REG_AW(REG_AW)) u_lu (
      .id_rs1_i  (id_rs1_i),
      .id_rs2_i  (id_rs2_i),
      .id_use1_i (id_use1_i),
      .id_use2_i (id_use2_i),
      .ex_rd_i   (ex_rd),
      .ex_wr_i   (ex_wr),
      .ex_load_i (ex_load),
      .flush_i   (flush_i),
      .stall_o   (stall)
   );

   assign opnd_src[0] = ex_rs1;
   assign opnd_src[1] = ex_rs2;
   assign opnd_use[0] = ex_use1;
   assign opnd_use[1] = ex_use2;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         phc_fwd_pick #(.REG_AW(REG_AW)) u_pick (
            .src_i    (opnd_src[g]),
            .use_i    (opnd_use[g]),
            .mem_rd_i (mem_rd),
            .mem_wr_i (mem_wr),
            .wb_rd_i  (wb_rd),
            .wb_wr_i  (wb_wr),
            .sel_o    (opnd_sel[g])
         );
      end
   endgenerate

   assign fwd_a_o     = opnd_sel[0];
   assign fwd_b_o     = opnd_sel[1];
   assign pc_hold_o   = stall;
   assign ifid_hold_o = stall;
   assign ex_bubble_o = stall;
   assign ifid_clr_o  = flush_i;
   assign ex_wr_o     = ex_wr;
   assign ex_mw_o     = ex_mw;

endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
   parameter int unsigned REG_AW = 5
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [REG_AW-1:0] id_rs1_i,
   input logic [REG_AW-1:0] id_rs2_i,
   input logic              id_use1_i,
   input logic              id_use2_i,
   input logic              id_wr_i,
   input logic              id_mw_i,
   input logic              flush_i,
   input logic [1:0]        fwd_a_o,
   input logic [1:0]        fwd_b_o,
   input logic              pc_hold_o,
   input logic              ex_wr_o,
   input logic              ex_mw_o
);

   logic past_ok;

   always_ff @(posedge clk_i) begin
      if (rst_i) past_ok <= 1'b0;
      else       past_ok <= 1'b1;
   end

   AST_FWD_A_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(fwd_a_o)); // R3
   AST_FWD_B_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(fwd_b_o)); // R3
   AST_STALL_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      pc_hold_o |=> !pc_hold_o); // R6
   AST_BUBBLE_CTRL: assert property (@(posedge clk_i) disable iff (rst_i)
      pc_hold_o |=> (!ex_wr_o && !ex_mw_o)); // R7
   AST_FLUSH_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      flush_i |-> !pc_hold_o); // R9
   AST_R0_NO_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
      ((!id_use1_i || id_rs1_i == '0) && (!id_use2_i || id_rs2_i == '0)) |-> !pc_hold_o); // R4
   AST_R0_NO_FWD: assert property (@(posedge clk_i) disable iff (rst_i)
      (past_ok && $past(id_rs1_i == '0)) |-> (fwd_a_o == 2'b00)); // R4
   AST_CTRL_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
      (past_ok && $past(!pc_hold_o)) |-> (ex_wr_o == $past(id_wr_i) && ex_mw_o == $past(id_mw_i))); // R12

endmodule

bind pipe_hazard_ctrl phc_checker #(.REG_AW(REG_AW)) chk_i (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .id_rs1_i  (id_rs1_i),
   .id_rs2_i  (id_rs2_i),
   .id_use1_i (id_use1_i),
   .id_use2_i (id_use2_i),
   .id_wr_i   (id_wr_i),
   .id_mw_i   (id_mw_i),
   .flush_i   (flush_i),
   .fwd_a_o   (fwd_a_o),
   .fwd_b_o   (fwd_b_o),
   .pc_hold_o (pc_hold_o),
   .ex_wr_o   (ex_wr_o),
   .ex_mw_o   (ex_mw_o)
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;

   localparam int unsigned AW = 5;

   typedef struct packed {
      logic [AW-1:0] rs1;
      logic [AW-1:0] rs2;
      logic          u1;
      logic          u2;
      logic [AW-1:0] rd;
      logic          wr;
      logic          ld;
      logic          mw;
      logic          fl;
      logic          e_st;
      logic [1:0]    e_fa;
      logic [1:0]    e_fb;
      logic          e_ew;
      logic          e_em;
      logic          e_clr;
   } vec_t;

   localparam int NV = 25;
   // Row k: instruction presented in decode; expected outputs in the same cycle.
   // Selects describe the row before; a stalled row is repeated once.
   localparam vec_t VEC [NV] = '{
      '{5'd2, 5'd3, 1'b1,1'b1, 5'd1, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0}, // 0 reset state
      '{5'd1, 5'd5, 1'b1,1'b1, 5'd4, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 1 R8 ALU dep, no stall
      '{5'd1, 5'd4, 1'b1,1'b1, 5'd6, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b10,2'b00,1'b1,1'b0,1'b0}, // 2 R1
      '{5'd4, 5'd6, 1'b1,1'b1, 5'd7, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b01,2'b10,1'b1,1'b0,1'b0}, // 3 R1 R2
      '{5'd0, 5'd0, 1'b1,1'b0, 5'd8, 1'b1,1'b1,1'b0,1'b0, 1'b0,2'b01,2'b10,1'b1,1'b0,1'b0}, // 4 load x8
      '{5'd8, 5'd7, 1'b1,1'b1, 5'd9, 1'b1,1'b0,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b1,1'b0,1'b0}, // 5 R6 stall
      '{5'd8, 5'd7, 1'b1,1'b1, 5'd9, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0}, // 6 R6 R7 bubble
      '{5'd8, 5'd9, 1'b1,1'b1, 5'd0, 1'b0,1'b0,1'b1,1'b0, 1'b0,2'b01,2'b00,1'b1,1'b0,1'b0}, // 7 R10 store
      '{5'd9, 5'd9, 1'b1,1'b1, 5'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b10,1'b0,1'b1,1'b0}, // 8 R12 store in EX
      '{5'd0, 5'd0, 1'b1,1'b1, 5'd10,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b01,2'b01,1'b1,1'b0,1'b0}, // 9 R2
      '{5'd1, 5'd0, 1'b1,1'b0, 5'd11,1'b1,1'b1,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 10 R4 x0 dest
      '{5'd11,5'd0, 1'b1,1'b0, 5'd12,1'b1,1'b0,1'b0,1'b1, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b1}, // 11 R9 flush wins
      '{5'd11,5'd0, 1'b1,1'b0, 5'd13,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b10,2'b00,1'b1,1'b0,1'b0}, // 12 R10 load in MEM
      '{5'd2, 5'd0, 1'b1,1'b0, 5'd14,1'b1,1'b1,1'b0,1'b0, 1'b0,2'b01,2'b00,1'b1,1'b0,1'b0}, // 13
      '{5'd3, 5'd14,1'b1,1'b0, 5'd15,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 14 R5 unused src
      '{5'd1, 5'd0, 1'b1,1'b0, 5'd0, 1'b1,1'b1,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 15 R5 no fwd
      '{5'd0, 5'd0, 1'b1,1'b0, 5'd16,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 16 R4 load to x0
      '{5'd1, 5'd1, 1'b1,1'b1, 5'd20,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 17
      '{5'd2, 5'd2, 1'b1,1'b1, 5'd20,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 18
      '{5'd20,5'd20,1'b1,1'b1, 5'd21,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b1,1'b0,1'b0}, // 19
      '{5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,2'b10,2'b10,1'b1,1'b0,1'b0}, // 20 R3 priority
      '{5'd0, 5'd0, 1'b1,1'b0, 5'd22,1'b1,1'b1,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0}, // 21
      '{5'd5, 5'd22,1'b1,1'b1, 5'd23,1'b1,1'b0,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b1,1'b0,1'b0}, // 22 R6 via rs2
      '{5'd5, 5'd22,1'b1,1'b1, 5'd23,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0}, // 23 R7
      '{5'd0, 5'd0, 1'b0,1'b0, 5'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b01,1'b1,1'b0,1'b0}  // 24 R2
   };

   logic          clk_i = 1'b0;
   logic          rst_i;
   logic [AW-1:0] id_rs1_i, id_rs2_i, id_rd_i;
   logic          id_use1_i, id_use2_i, id_wr_i, id_load_i, id_mw_i, flush_i;
   logic [1:0]    fwd_a_o, fwd_b_o;
   logic          pc_hold_o, ifid_hold_o, ex_bubble_o, ifid_clr_o, ex_wr_o, ex_mw_o;

   int n_chk  = 0;
   int n_err  = 0;
   bit done   = 1'b0;

   always #2 clk_i = ~clk_i;

   pipe_hazard_ctrl #(.REG_AW(AW)) dut_i (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .id_rs1_i    (id_rs1_i),
      .id_rs2_i    (id_rs2_i),
      .id_use1_i   (id_use1_i),
      .id_use2_i   (id_use2_i),
      .id_rd_i     (id_rd_i),
      .id_wr_i     (id_wr_i),
      .id_load_i   (id_load_i),
      .id_mw_i     (id_mw_i),
      .flush_i     (flush_i),
      .fwd_a_o     (fwd_a_o),
      .fwd_b_o     (fwd_b_o),
      .pc_hold_o   (pc_hold_o),
      .ifid_hold_o (ifid_hold_o),
      .ex_bubble_o (ex_bubble_o),
      .ifid_clr_o  (ifid_clr_o),
      .ex_wr_o     (ex_wr_o),
      .ex_mw_o     (ex_mw_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      id_rs1_i  = v.rs1;
      id_rs2_i  = v.rs2;
      id_use1_i = v.u1;
      id_use2_i = v.u2;
      id_rd_i   = v.rd;
      id_wr_i   = v.wr;
      id_load_i = v.ld;
      id_mw_i   = v.mw;
      flush_i   = v.fl;
   endtask

   initial begin
      rst_i = 1'b1;
      drive('0);
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
      #1;
      chk("R11 reset fwd_a", int'(fwd_a_o), 0);
      chk("R11 reset ex_wr", int'(ex_wr_o), 0);
      chk("R11 reset stall", int'(pc_hold_o), 0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk_i);
         drive(VEC[k]);
         #1;
         $display("row %0d", k);
         chk("R6/R8/R9 pc_hold",   int'(pc_hold_o),   int'(VEC[k].e_st));
         chk("R6 ifid_hold",       int'(ifid_hold_o), int'(VEC[k].e_st));
         chk("R6 ex_bubble",       int'(ex_bubble_o), int'(VEC[k].e_st));
         chk("R1/R2/R3/R4 fwd_a",  int'(fwd_a_o),     int'(VEC[k].e_fa));
         chk("R1/R2/R5 fwd_b",     int'(fwd_b_o),     int'(VEC[k].e_fb));
         chk("R7/R12 ex_wr",       int'(ex_wr_o),     int'(VEC[k].e_ew));
         chk("R7/R12 ex_mw",       int'(ex_mw_o),     int'(VEC[k].e_em));
         chk("R9 ifid_clr",        int'(ifid_clr_o),  int'(VEC[k].e_clr));
      end

      // Directed: R11 reset drops a load already in execute.
      @(negedge clk_i);
      drive('{5'd1,5'd0,1'b1,1'b0,5'd3,1'b1,1'b1,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0});
      @(negedge clk_i);
      drive('{5'd3,5'd0,1'b1,1'b0,5'd4,1'b1,1'b0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0});
      #1;
      chk("R6 stall before reset", int'(pc_hold_o), 1);
      rst_i = 1'b1;
      @(negedge clk_i);
      #1;
      chk("R11 stall after reset", int'(pc_hold_o), 0);
      chk("R11 ex_wr after reset", int'(ex_wr_o), 0);
      chk("R11 fwd_b after reset", int'(fwd_b_o), 0);
      rst_i = 1'b0;

      // Directed: R9 flush alone with no hazard.
      @(negedge clk_i);
      drive('{5'd0,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,1'b0,1'b1, 1'b0,2'b00,2'b00,1'b0,1'b0,1'b0});
      #1;
      chk("R9 flush clr", int'(ifid_clr_o), 1);
      chk("R9 flush no hold", int'(ifid_hold_o), 0);
      @(negedge clk_i);
      drive('0);
      #1;
      chk("R9 clr drops", int'(ifid_clr_o), 0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 2000; c++) begin
         @(posedge clk_i);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule